// File: doc/BRIEF.md
# PS/2 Frame Receiver

This block takes the two wires of a PS/2 link, driven by a keyboard or mouse, and recovers the bytes the device sends to the host. Both wires rest high between transfers. Each wire first passes through a two-stage synchronizer into the system clock domain. A run-length glitch filter follows the synchronizer. A falling edge on the filtered device clock is the moment to capture the filtered data level.

Eleven captured bits make one word: a low start bit, eight payload bits with the least significant bit first, a parity bit, and a high stop bit. The payload plus the parity bit must hold an odd number of ones. A correct word produces a one-cycle `data_valid` strobe and updates `rx_byte`. A word with a bad start bit, stop bit or parity produces a one-cycle `frame_error` strobe instead.

If the device clock stops partway through a word for longer than the timeout, the partial word is dropped. The receiver then waits for a fresh start bit. The system clock rate, the filter length and the timeout are all parameters.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is held and right after it is released, `data_valid` and `frame_error` are 0 and `rx_byte` is 0x00.
- R2: A word is captured at 11 filtered falling edges of `ps2_clk_in`. Captured bit 0 is the start bit, bits 1 to 8 are payload bits 0 to 7, bit 9 is parity and bit 10 is the stop bit. A word with start 0, stop 1 and odd parity raises `data_valid` for one cycle and puts the payload on `rx_byte`.
- R3: A word whose payload plus parity bit holds an even number of ones raises `frame_error` for one cycle and does not raise `data_valid`.
- R4: A word whose start bit is 1 raises `frame_error` and does not raise `data_valid`.
- R5: A word whose stop bit is 0 raises `frame_error` and does not raise `data_valid`.
- R6: A change on either PS/2 wire that lasts fewer than `FILTER_CYCLES` system cycles after synchronization is ignored. A two-cycle low pulse on `ps2_clk_in` during a high phase adds no bit to the word.
- R7: If a word is partly received and no falling edge arrives for `TIMEOUT_US` microseconds of system clock, the partial bits are dropped without any strobe. The next 11 edges are then taken as a new word.
- R8: `data_valid` and `frame_error` are each at most one cycle wide and are never high together.
- R9: `rx_byte` changes only in a cycle where `data_valid` is high. A rejected word leaves it holding the last good byte.
- R10: Words sent back to back, with only the idle gap of one clock phase, are each reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_in | input | 1 | Device-driven PS/2 clock wire, asynchronous |
| ps2_data_in | input | 1 | Device-driven PS/2 data wire, asynchronous |
| rx_byte | output | 8 | Last good payload byte |
| data_valid | output | 1 | One-cycle strobe: a good word was received |
| frame_error | output | 1 | One-cycle strobe: a word failed a start, stop or parity check |

## Verification
A bit counter that is off by one shows up on the first word after the fault, and it keeps showing up. The payload appears shifted, or good words are rejected by the start or stop check about one system cycle after the eleventh edge. A filter that passes glitches adds an extra bit, so the same misalignment appears within that word. A timeout that never fires leaves stale bits, so the first word after an abandoned transfer is corrupted. A timeout that fires too early breaks words only when edges are slow. The bench therefore runs a full word after each disturbance and compares the byte and both strobe counts.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  localparam int WORD_BITS = 11;

  // Captured word, bit 0 is the first bit on the wire (start bit).
  typedef struct packed {
    logic       stop;
    logic       parity;
    logic [7:0] payload;
    logic       start;
  } ps2_word_t;

  // Odd parity over payload and parity bit.
  function automatic logic parity_odd(input logic [7:0] payload, input logic par);
    return ^{par, payload};
  endfunction

  // Full acceptance rule for one captured word.
  function automatic logic word_is_good(input ps2_word_t w);
    return (w.start == 1'b0) && (w.stop == 1'b1) && parity_odd(w.payload, w.parity);
  endfunction

  // Timeout length in system cycles.
  function automatic int timeout_cycles(input int clk_hz, input int usec);
    return (clk_hz / 1_000_000) * usec;
  endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int FILTER_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);

  localparam int CW = $clog2(FILTER_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;
  logic          level_q;
  logic          differs;

  assign differs  = sync_q[1] != level_q;
  assign line_out = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      run_cnt <= '0;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      if (!differs) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(FILTER_CYCLES - 1)) begin
        level_q <= sync_q[1];
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  initial begin
    if (FILTER_CYCLES < 2) $error("FILTER_CYCLES must be at least 2");
  end

  // A new filtered level must have been seen on the synchronizer for the
  // two cycles before it took effect.
  AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync_q[1]) == level_q)); // R6
  AST_FILTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync_q[1], 2) == level_q)); // R6

endmodule

// File: rtl/ps2_fall_detect.sv
module ps2_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic fall_pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_in;
  end

  assign fall_pulse = prev_q & ~level_in;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse); // R2

endmodule

// File: rtl/ps2_word_assembler.sv
module ps2_word_assembler
  import ps2_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_strobe,
  input  logic                 bit_value,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word_bits,
  output logic                 timeout_hit
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(WORD_BITS + 1);

  logic [BW-1:0]        bit_cnt;
  logic [TW-1:0]        idle_cnt;
  logic [WORD_BITS-1:0] shreg;
  logic                 in_word;

  assign in_word     = bit_cnt != '0;
  assign timeout_hit = in_word && !bit_strobe && (idle_cnt == TW'(TIMEOUT_CYCLES - 1));
  assign word_bits   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      idle_cnt  <= '0;
      shreg     <= '1;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (bit_strobe) begin
        shreg    <= {bit_value, shreg[WORD_BITS-1:1]};
        idle_cnt <= '0;
        if (bit_cnt == BW'(WORD_BITS - 1)) begin
          bit_cnt   <= '0;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (timeout_hit) begin
        bit_cnt  <= '0;
        idle_cnt <= '0;
      end else if (in_word) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  AST_BIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BW'(WORD_BITS - 1)); // R2
  AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (bit_cnt == '0) && !word_done); // R7
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < TW'(TIMEOUT_CYCLES)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R8

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int CLK_FREQ_HZ   = 100_000_000,
  parameter int FILTER_CYCLES = 8,
  parameter int TIMEOUT_US    = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic [7:0] rx_byte,
  output logic       data_valid,
  output logic       frame_error
);

  localparam int TIMEOUT_CYC = timeout_cycles(CLK_FREQ_HZ, TIMEOUT_US);
  localparam int NUM_LINES   = 2;
  localparam int LINE_CLK    = 0;
  localparam int LINE_DATA   = 1;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] clean_lines;
  logic                 bit_strobe;
  logic                 word_done;
  logic                 timeout_hit;
  logic [WORD_BITS-1:0] word_bits;
  ps2_word_t            word_view;
  logic                 word_good;

  assign raw_lines = {ps2_data_in, ps2_clk_in};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ps2_line_filter #(.FILTER_CYCLES(FILTER_CYCLES)) i_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (raw_lines[g]),
      .line_out (clean_lines[g])
    );
  end

  ps2_fall_detect i_fall (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_in   (clean_lines[LINE_CLK]),
    .fall_pulse (bit_strobe)
  );

  ps2_word_assembler #(.TIMEOUT_CYCLES(TIMEOUT_CYC)) i_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_strobe  (bit_strobe),
    .bit_value   (clean_lines[LINE_DATA]),
    .word_done   (word_done),
    .word_bits   (word_bits),
    .timeout_hit (timeout_hit)
  );

  assign word_view = ps2_word_t'(word_bits);
  assign word_good = word_is_good(word_view);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      data_valid  <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      data_valid  <= word_done && word_good;
      frame_error <= word_done && !word_good;
      if (word_done && word_good) rx_byte <= word_view.payload;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R8
  AST_ERROR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error); // R8
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_valid && frame_error)); // R8
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte != $past(rx_byte)) |-> data_valid); // R9
  AST_STROBE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid || frame_error) |-> $past(word_done)); // R2

endmodule

// File: tb/test_ps2_frame_rx.sv
module test_ps2_frame_rx;

  localparam int HALF   = 40;
  localparam int FILT   = 4;
  localparam int CLK_HZ = 10_000_000;
  localparam int TO_US  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk = 1'b1;
  logic       ps2_dat = 1'b1;
  logic [7:0] rx_byte;
  logic       data_valid;
  logic       frame_error;

  int checks = 0;
  int fails = 0;
  int dv_cnt = 0;
  int fe_cnt = 0;
  int wide_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_dv = 1'b0;
  logic prev_fe = 1'b0;

  always #2.5 clk = ~clk;

  ps2_frame_rx #(.CLK_FREQ_HZ(CLK_HZ), .FILTER_CYCLES(FILT), .TIMEOUT_US(TO_US)) i_ps2_frame_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ps2_clk_in  (ps2_clk),
    .ps2_data_in (ps2_dat),
    .rx_byte     (rx_byte),
    .data_valid  (data_valid),
    .frame_error (frame_error)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_valid) begin dv_cnt++; last_byte = rx_byte; end
      if (frame_error) fe_cnt++;
      if ((data_valid && prev_dv) || (frame_error && prev_fe) || (data_valid && frame_error))
        wide_cnt++;
      prev_dv = data_valid;
      prev_fe = frame_error;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive nbits bits of w, bit 0 first. Optional short clock glitch in bit glitch_at.
  task automatic drive_bits(input logic [10:0] w, input int nbits, input int glitch_at);
    for (int i = 0; i < nbits; i++) begin
      ps2_dat = w[i];
      wait_cyc(8);
      if (i == glitch_at) begin
        ps2_clk = 1'b0; wait_cyc(2); ps2_clk = 1'b1;
      end else begin
        wait_cyc(2);
      end
      wait_cyc(HALF / 2 - 10);
      ps2_clk = 1'b0;
      wait_cyc(HALF);
      ps2_clk = 1'b1;
      wait_cyc(HALF / 2);
    end
  endtask

  function automatic logic [10:0] make_word(input logic [7:0] b, input logic start_b,
                                             input logic stop_b, input logic flip_par);
    logic par;
    par = ~(^b) ^ flip_par;
    return {stop_b, par, b, start_b};
  endfunction

  task automatic send_word(input logic [7:0] b, input logic start_b, input logic stop_b,
                           input logic flip_par, input int glitch_at);
    drive_bits(make_word(b, start_b, stop_b, flip_par), 11, glitch_at);
    ps2_dat = 1'b1;
    wait_cyc(20);
  endtask

  task automatic t_reset();
    check(data_valid == 1'b0, "R1 data_valid", data_valid, 0);
    check(frame_error == 1'b0, "R1 frame_error", frame_error, 0);
    check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
  endtask

  task automatic t_good(input logic [7:0] b);
    int dv0, fe0;
    dv0 = dv_cnt; fe0 = fe_cnt;
    send_word(b, 1'b0, 1'b1, 1'b0, -1);
    check(dv_cnt == dv0 + 1 && fe_cnt == fe0, "R2 strobe count", dv_cnt - dv0, 1);
    check(last_byte == b && rx_byte == b, "R2 byte", rx_byte, b);
  endtask

  task automatic t_bad(input string req, input logic start_b, input logic stop_b, input logic flip);
    int dv0, fe0;
    logic [7:0] held;
    dv0 = dv_cnt; fe0 = fe_cnt; held = rx_byte;
    send_word(8'h3C, start_b, stop_b, flip, -1);
    check(fe_cnt == fe0 + 1, {req, " frame_error"}, fe_cnt - fe0, 1);
    check(dv_cnt == dv0, {req, " no data_valid"}, dv_cnt - dv0, 0);
    check(rx_byte == held, "R9 byte held after rejected word", rx_byte, held);
  endtask

  task automatic t_back_to_back();
    int dv0;
    dv0 = dv_cnt;
    drive_bits(make_word(8'h12, 1'b0, 1'b1, 1'b0), 11, -1);
    drive_bits(make_word(8'hE7, 1'b0, 1'b1, 1'b0), 11, -1);
    ps2_dat = 1'b1;
    wait_cyc(20);
    check(dv_cnt == dv0 + 2, "R10 two words reported", dv_cnt - dv0, 2);
    check(last_byte == 8'hE7, "R10 second byte", last_byte, 8'hE7);
  endtask

  task automatic t_glitch();
    int dv0, fe0;
    dv0 = dv_cnt; fe0 = fe_cnt;
    send_word(8'h96, 1'b0, 1'b1, 1'b0, 4);
    check(dv_cnt == dv0 + 1 && fe_cnt == fe0, "R6 glitch ignored count", dv_cnt - dv0, 1);
    check(rx_byte == 8'h96, "R6 glitch ignored byte", rx_byte, 8'h96);
  endtask

  task automatic t_timeout();
    int dv0, fe0;
    dv0 = dv_cnt; fe0 = fe_cnt;
    drive_bits(make_word(8'hFF, 1'b0, 1'b1, 1'b0), 5, -1);
    ps2_dat = 1'b1;
    wait_cyc(1500);
    check(dv_cnt == dv0 && fe_cnt == fe0, "R7 no strobe on dropped bits", fe_cnt - fe0, 0);
    send_word(8'h5A, 1'b0, 1'b1, 1'b0, -1);
    check(dv_cnt == dv0 + 1 && fe_cnt == fe0, "R7 next word clean", dv_cnt - dv0, 1);
    check(rx_byte == 8'h5A, "R7 next word byte", rx_byte, 8'h5A);
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'hFF);
    t_good(8'h01);
    t_bad("R3", 1'b0, 1'b1, 1'b1);
    t_bad("R4", 1'b1, 1'b1, 1'b0);
    t_bad("R5", 1'b0, 1'b0, 1'b0);
    t_back_to_back();
    t_glitch();
    t_timeout();
    check(wide_cnt == 0, "R8 strobe width and overlap", wide_cnt, 0);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

endmodule